// File: doc/BRIEF.md
# Shared Multiply, Multiply-Accumulate and Divide Unit

This block is a small arithmetic coprocessor on a simple 16-bit register bus. Software writes two operand words into an operand pair (A-high and A-low), selects a mode in a control register and reads the answer back. The three modes are a 16x16 multiply, a 16x16 multiply-accumulate into a 32-bit register C, and an unsigned 32-by-16 division. Multiply and multiply-accumulate each have a signed and an unsigned variant. Signed operands are two's complement.

The operand pair has two roles. In the multiply modes, A-high holds the multiplier and A-low holds the multiplicand. In division mode, A-high:A-low is the 32-bit dividend, with A-high as the upper half. When division finishes, the quotient is written back over it in the same order. The divisor sits in register B and the remainder lands in the low half of C. Division is a restoring divider that produces one quotient bit per clock. While it runs, the control register reads back a fixed "busy" pattern, and the busy output is high.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, every readable register reads 0000H: A-high (addr 0), A-low (addr 1), B (addr 2), C low (addr 3), C high (addr 4) and control (addr 5). The busy and ovf outputs are 0.
- R2: A bus write (we=1 at a rising edge) to addresses 0..4 stores wdata. The combinational rdata for that address returns it.
- R3: Control bits [7:6] select the mode: 00 multiply, 01 multiply-accumulate, 1x divide. Bit 3 selects signed operation in the multiply modes. With control 00H, a write to A-low starts the operation. C holds the unsigned product A-high*A-low after the second rising edge counted from the write edge.
- R4: With control 08H, the same trigger stores the two's-complement signed 32-bit product in C.
- R5: With control 40H, the trigger adds the unsigned product to C modulo 2^32. A carry out of bit 31 sets ovf. Outside division mode, ovf reads at control bit 1.
- R6: With control 48H, the trigger adds the signed product to C. A two's-complement overflow sets ovf. ovf is sticky through later operations, and any write to the control register clears it.
- R7: Writing control with bit 7 and bit 0 both set starts a division. Busy is high for exactly 32 clocks. During that time control reads 81H (or C1H if bit 6 was written 1). At the end, A-high:A-low holds the unsigned quotient, C low holds the remainder, C high is 0000H, and control reads 80H or C0H.
- R8: With divisor B = 0, division gives quotient FFFFFFFFH and a remainder equal to A-low of the dividend.
- R9: Writes to the control register while a division is running are ignored: busy stays high and control still reads 81H.
- R10: In division mode with no division running, writing A-low does not change C and does not start anything.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Write strobe |
| addr | input | 3 | Register address: 0 A-high, 1 A-low, 2 B, 3 C low, 4 C high, 5 control |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| busy | output | 1 | Division in progress |
| ovf | output | 1 | Sticky accumulate overflow flag |

## Verification
The checks on the divider take two things for granted while busy is high: the operand pair and register B are not written by the bus, and control writes carry no new start. The quotient-and-remainder identity is checked against the dividend and divisor captured when the division started. Multiply checks assume the operand pair is not rewritten in the clock between the A-low write and the result. The stimulus respects all of this. It touches nothing during a division except control writes and reads, and it waits a full clock after each A-low trigger before the next operand write that matters.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          busy,
  output logic          ovf
);
  localparam int PW = 2 * DW;
  localparam int CW = $clog2(PW);

  logic [DW-1:0] a_hi, a_lo, b_q;
  logic [PW-1:0] c_q;
  logic [1:0]    mode;
  logic          sgn, go;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rem;

  wire is_div  = mode[1];
  wire is_mac  = (mode == 2'b01);
  wire ctl_wr  = we && addr == 3'd5;
  wire trig    = we && addr == 3'd1 && !is_div;

  wire [PW-1:0] prod_u = {{DW{1'b0}}, a_hi} * {{DW{1'b0}}, a_lo};
  wire signed [PW-1:0] prod_s = $signed({{DW{a_hi[DW-1]}}, a_hi}) * $signed({{DW{a_lo[DW-1]}}, a_lo});
  wire [PW-1:0] prod   = sgn ? prod_s : prod_u;
  wire [PW:0]   sum    = {1'b0, c_q} + {1'b0, prod};
  wire          ov_u   = sum[PW];
  wire          ov_s   = (c_q[PW-1] == prod[PW-1]) && (sum[PW-1] != c_q[PW-1]);

  wire [PW-1:0] a_cat  = {a_hi, a_lo};
  wire [DW:0]   r_sh   = {rem, a_cat[PW-1]};
  wire          ge     = r_sh >= {1'b0, b_q};
  wire [DW:0]   r_sub  = r_sh - {1'b0, b_q};
  wire [DW-1:0] rem_n  = ge ? r_sub[DW-1:0] : r_sh[DW-1:0];
  wire [PW-1:0] a_n    = {a_cat[PW-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hi <= '0; a_lo <= '0; b_q <= '0; c_q <= '0;
      mode <= '0; sgn <= 1'b0; busy <= 1'b0; ovf <= 1'b0;
      go <= 1'b0; cnt <= '0; rem <= '0;
    end else begin
      go <= trig;
      if (we) begin
        case (addr)
          3'd0: a_hi <= wdata;
          3'd1: a_lo <= wdata;
          3'd2: b_q  <= wdata;
          3'd3: c_q[DW-1:0]  <= wdata;
          3'd4: c_q[PW-1:DW] <= wdata;
          default: ;
        endcase
      end
      if (ctl_wr && !busy) begin
        mode <= wdata[7:6];
        sgn  <= wdata[3];
        ovf  <= 1'b0;
        busy <= wdata[7] & wdata[0];
        cnt  <= '0;
        rem  <= '0;
      end
      if (go) begin
        if (is_mac) begin
          c_q <= sum[PW-1:0];
          if (sgn ? ov_s : ov_u) ovf <= 1'b1;
        end else if (!is_div) begin
          c_q <= prod;
        end
      end
      if (busy) begin
        {a_hi, a_lo} <= a_n;
        rem <= rem_n;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(PW - 1)) begin
          busy <= 1'b0;
          c_q  <= {{DW{1'b0}}, rem_n};
        end
      end
    end
  end

  wire [7:0] ctl_rd = is_div ? {mode, 5'b0, busy} : {mode, 2'b0, sgn, 1'b0, ovf, 1'b0};

  always_comb begin
    case (addr)
      3'd0:    rdata = a_hi;
      3'd1:    rdata = a_lo;
      3'd2:    rdata = b_q;
      3'd3:    rdata = c_q[DW-1:0];
      3'd4:    rdata = c_q[PW-1:DW];
      3'd5:    rdata = DW'(ctl_rd);
      default: rdata = '0;
    endcase
  end
endmodule

module muldiv_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [2:0]    addr,
  input logic          busy,
  input logic          ovf,
  input logic          go,
  input logic [1:0]    mode,
  input logic          sgn,
  input logic [DW-1:0] a_hi,
  input logic [DW-1:0] a_lo,
  input logic [DW-1:0] b_q,
  input logic [2*DW-1:0] c_q
);
  localparam int PW = 2 * DW;
  localparam int BW = $clog2(PW) + 1;

  logic          busy_d;
  logic [BW-1:0] bcnt;
  logic [PW-1:0] dv_n;
  logic [DW-1:0] dv_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d <= 1'b0; bcnt <= '0; dv_n <= '0; dv_b <= '0;
    end else begin
      busy_d <= busy;
      if (busy && !busy_d) begin
        bcnt <= BW'(1);
        dv_n <= {a_hi, a_lo};
        dv_b <= b_q;
      end else if (busy) begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  wire [3*DW-1:0] recon = {{DW{1'b0}}, a_hi, a_lo} * {{PW{1'b0}}, dv_b} + {{PW{1'b0}}, c_q[DW-1:0]};

  // R7
  div_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_d && !busy) |-> (bcnt == BW'(PW)));

  // R7
  div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_d && !busy && dv_b != '0) |-> (recon == {{DW{1'b0}}, dv_n} && c_q[DW-1:0] < dv_b));

  // R8
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_d && !busy && dv_b == '0) |-> ({a_hi, a_lo} == '1 && c_q[DW-1:0] == dv_n[DW-1:0]));

  // R9
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mode[1]);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(we && addr == 3'd5)) |=> ovf);

  // R3
  mul_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 2'b00 && !sgn) |=> (c_q == {{DW{1'b0}}, $past(a_hi)} * {{DW{1'b0}}, $past(a_lo)}));

  // R10
  div_notrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !busy && !busy_d && !(we && (addr == 3'd3 || addr == 3'd4))) |=> $stable(c_q));
endmodule

bind muldiv_unit muldiv_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .busy(busy), .ovf(ovf),
  .go(go), .mode(mode), .sgn(sgn), .a_hi(a_hi), .a_lo(a_lo), .b_q(b_q), .c_q(c_q)
);

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic busy, ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  event mon_ev;

  muldiv_unit u0 (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
                  .rdata(rdata), .busy(busy), .ovf(ovf));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(mon_ev);
    check(tag_q.pop_front(), {16'b0, rdata}, {16'b0, exp_q.pop_front()});
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; #1; -> mon_ev; #1;
  endtask

  task automatic rd_c(input logic [31:0] e, input string tag);
    rd(3'd3, e[15:0], tag);
    rd(3'd4, e[31:16], tag);
  endtask

  task automatic op(input logic [15:0] h, input logic [15:0] l);
    wr(3'd0, h); wr(3'd1, l); @(negedge clk);
  endtask

  task automatic set_c(input logic [31:0] v);
    wr(3'd3, v[15:0]); wr(3'd4, v[31:16]);
  endtask

  function automatic logic [31:0] smul(input logic [15:0] x, input logic [15:0] y);
    int p;
    p = int'($signed(x)) * int'($signed(y));
    return p;
  endfunction

  task automatic divide(input logic [31:0] n, input logic [15:0] d, input logic [7:0] ctl, input string tag);
    logic [31:0] q;
    logic [15:0] r;
    int cyc;
    q = (d == 0) ? 32'hFFFF_FFFF : n / {16'b0, d};
    r = (d == 0) ? n[15:0] : 16'(n % {16'b0, d});
    wr(3'd5, ctl & 8'hFE);
    wr(3'd0, n[31:16]); wr(3'd1, n[15:0]); wr(3'd2, d);
    wr(3'd5, ctl);
    rd(3'd5, {8'b0, ctl}, {tag, " ctl busy"});
    cyc = 0;
    while (busy && cyc < 100) begin cyc++; @(negedge clk); end
    check({tag, " busy cycles"}, cyc, 32);
    rd(3'd0, q[31:16], {tag, " quotient hi"});
    rd(3'd1, q[15:0], {tag, " quotient lo"});
    rd_c({16'b0, r}, {tag, " remainder"});
    rd(3'd5, {8'b0, ctl & 8'hFE}, {tag, " ctl done"});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] acc;
    logic [32:0] s33;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) rd(3'(i), 16'h0000, "R1 reset reg");
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 ovf", {31'b0, ovf}, 0);

    wr(3'd2, 16'h1234); rd(3'd2, 16'h1234, "R2 B");
    set_c(32'hBEEF_CAFE); rd_c(32'hBEEF_CAFE, "R2 C");
    wr(3'd0, 16'hA5A5); rd(3'd0, 16'hA5A5, "R2 A-high");

    wr(3'd5, 16'h0000);
    op(16'hFFFF, 16'hFFFF); rd_c(32'hFFFE_0001, "R3 mul ffff*ffff");
    op(16'h1234, 16'h5678); rd_c(32'h1234 * 32'h5678, "R3 mul 1234*5678");

    wr(3'd5, 16'h0008); rd(3'd5, 16'h0008, "R4 ctl");
    op(16'hFFFF, 16'h0003); rd_c(smul(16'hFFFF, 16'h0003), "R4 smul -1*3");
    op(16'h8000, 16'h8000); rd_c(32'h4000_0000, "R4 smul min*min");
    op(16'h7FFF, 16'h8000); rd_c(smul(16'h7FFF, 16'h8000), "R4 smul max*min");

    wr(3'd5, 16'h0040); set_c(32'h0);
    acc = 0;
    op(16'h0100, 16'h0200); acc += 32'h0002_0000;
    op(16'hFFFF, 16'h0010); acc += 32'h000F_FFF0;
    op(16'h0003, 16'h0005); acc += 32'd15;
    rd_c(acc, "R5 mac sum");
    check("R5 no ovf", {31'b0, ovf}, 0);
    set_c(32'hFFFF_FFFF);
    op(16'h0001, 16'h0002);
    s33 = {1'b0, 32'hFFFF_FFFF} + 33'd2;
    rd_c(s33[31:0], "R5 mac wrap");
    check("R5 ovf carry", {31'b0, ovf}, {31'b0, s33[32]});
    rd(3'd5, 16'h0042, "R5 ctl ovf bit");

    wr(3'd5, 16'h0048);
    check("R6 ovf cleared", {31'b0, ovf}, 0);
    set_c(32'h0);
    op(16'hFFFE, 16'h0003); rd_c(32'hFFFF_FFFA, "R6 smac -2*3");
    check("R6 no ovf", {31'b0, ovf}, 0);
    set_c(32'h7FFF_FFFF);
    op(16'h0001, 16'h0001); rd_c(32'h8000_0000, "R6 smac overflow");
    check("R6 ovf set", {31'b0, ovf}, 1);
    set_c(32'h0);
    op(16'h0000, 16'h0000);
    check("R6 ovf sticky", {31'b0, ovf}, 1);
    rd(3'd5, 16'h004A, "R6 ctl");

    divide(32'h1234_5678, 16'h00AB, 8'h81, "R7 div");
    divide(32'hFFFF_FFFF, 16'hFFFF, 8'hC1, "R7 div C1");
    divide(32'h0000_0005, 16'h0007, 8'h81, "R7 div small");
    divide(32'hDEAD_BEEF, 16'h0000, 8'h81, "R8 div by zero");

    wr(3'd5, 16'h0080);
    wr(3'd0, 16'h0003); wr(3'd1, 16'h0000); wr(3'd2, 16'h0010);
    wr(3'd5, 16'h0081);
    wr(3'd5, 16'h0000);
    check("R9 busy kept", {31'b0, busy}, 1);
    rd(3'd5, 16'h0081, "R9 ctl kept");
    while (busy) @(negedge clk);
    rd(3'd0, 16'h0000, "R9 quotient hi");
    rd(3'd1, 16'h3000, "R9 quotient lo");

    set_c(32'h1357_2468);
    wr(3'd1, 16'h0004); @(negedge clk); @(negedge clk);
    rd_c(32'h1357_2468, "R10 C unchanged");
    check("R10 busy", {31'b0, busy}, 0);

    #10;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule